// File: doc/BRIEF.md
# Phase-Parity Transaction Barrier

This block holds a small array of barrier objects for a processing cluster. Each object closes a phase only when two things are true at once: the number of arrivals it was armed with has been used up, and every byte transfer that producers announced has been reported finished. When both counts reach zero together the object flips its one-bit phase, re-arms its arrival count from the value given at setup, and starts the next phase. Waiters do not read counters; they hand in the parity of the phase they are waiting on and learn whether that phase has closed.

Operations arrive on a single command port: set up with an arrival count, arrive, arrive while announcing bytes, announce bytes only, report bytes finished, and tear down. A command may be marked as coming from another cluster member; such a command carries a target rank and a predicate and acts only when the predicate is set and the rank names this instance. A combinational test-wait port answers at once, and a try-wait engine polls one object until its phase closes or a tick limit runs out. Misuse (bad setup count, use of a torn-down object, byte or arrival underflow) is reported on a registered error code and leaves the object untouched.

Top module: `phase_tx_barrier`

## Requirements
- R1: A setup command (code 1) with a count from 1 to MAX_ARRIVE marks the object valid, with phase 0, that many arrivals pending, no bytes pending and error code 0.
- R2: A setup command with count 0 or above MAX_ARRIVE returns error code 1 and leaves the object unchanged.
- R3: An arrive (code 2) removes one pending arrival; when pending arrivals and pending bytes are both zero afterwards, the phase bit flips and pending arrivals reload from the setup count.
- R4: An arrive-with-bytes (code 3) removes one pending arrival and adds the value to pending bytes; the phase cannot close while bytes remain pending.
- R5: A bytes-announce (code 4) adds the value to pending bytes without removing an arrival.
- R6: A bytes-finished (code 5) subtracts the value from pending bytes and closes the phase when both counts are then zero.
- R7: A bytes-finished larger than the pending bytes, or an arrive when no arrivals are pending, returns error code 3 and changes nothing.
- R8: A command marked remote acts only when its predicate is 1 and its rank equals LOCAL_RANK; otherwise it has no effect and reports error code 0. Unmarked commands always act.
- R9: The test-wait output is 1 exactly when the selected object's phase bit differs from the supplied parity.
- R10: A try-wait request reports done with ok=1 one cycle after the first cycle it sees the phase differ from the parity, or done with ok=0 after TIMEOUT_TICKS cycles without that.
- R11: Objects are invalid out of reset; a teardown (code 6) makes an object invalid with phase 0; any command other than setup or teardown on an invalid object returns error code 2 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Command: 0 none, 1 setup, 2 arrive, 3 arrive with bytes, 4 announce bytes, 5 bytes finished, 6 teardown |
| op_slot | input | SLOT_W | Object index |
| op_value | input | VAL_W | Arrival count or byte amount |
| op_remote | input | 1 | Command comes from another cluster member |
| op_rank | input | RANK_W | Target rank of a remote command |
| op_pred | input | 1 | Predicate of a remote command |
| wait_slot | input | SLOT_W | Object tested by test-wait |
| wait_parity | input | 1 | Phase parity tested by test-wait |
| wait_done | output | 1 | Test-wait result |
| try_req | input | 1 | Start a try-wait (ignored while busy) |
| try_slot | input | SLOT_W | Object polled by try-wait |
| try_parity | input | 1 | Parity polled by try-wait |
| try_done | output | 1 | One-cycle pulse ending a try-wait |
| try_ok | output | 1 | Phase closed (1) or timed out (0), valid with try_done |
| try_busy | output | 1 | Try-wait in progress |
| err_code | output | 2 | Result of the previous cycle's command: 0 ok, 1 bad setup, 2 invalid object, 3 underflow |
| phase_o | output | NUM_SLOTS | Phase bit of each object |
| valid_o | output | NUM_SLOTS | Valid bit of each object |

## Verification
A command driven before clock edge N updates the object state and the error code at edge N, so the bench samples err_code, phase_o and valid_o at the falling edge after N, and compares them with a bench model stepped once per command. Test-wait is combinational on the registered phase and is checked in the same falling-edge window. A try-wait accepted at edge N first compares at edge N+1, so an already-closed phase yields done after one cycle, a phase closed by a command at edge N+1 yields done after two, and a phase that never closes yields done after exactly TIMEOUT_TICKS; the bench counts edges from the request and checks done and ok at that count.

// File: rtl/txbar_pkg.sv
package txbar_pkg;

    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_SETUP       = 3'd1,
        OP_ARRIVE      = 3'd2,
        OP_ARRIVE_TX   = 3'd3,
        OP_ANNOUNCE_TX = 3'd4,
        OP_FINISH_TX   = 3'd5,
        OP_TEARDOWN    = 3'd6
    } bar_op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_BAD_SETUP = 2'd1,
        ERR_NOT_VALID = 2'd2,
        ERR_UNDERFLOW = 2'd3
    } bar_err_e;

endpackage

// File: rtl/txbar_route.sv
module txbar_route #(
    parameter int NUM_SLOTS  = 4,
    parameter int RANK_W     = 2,
    parameter int LOCAL_RANK = 0,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [2:0]           op_code_i,
    input  logic [SLOT_W-1:0]    op_slot_i,
    input  logic                 op_remote_i,
    input  logic [RANK_W-1:0]    op_rank_i,
    input  logic                 op_pred_i,
    output logic [NUM_SLOTS-1:0] apply_o
);
    import txbar_pkg::*;

    logic legal_op;
    logic rank_hit;
    logic accept;

    always_comb begin
        legal_op = (op_code_i != OP_NONE) && (op_code_i != 3'd7);
        rank_hit = (op_rank_i == RANK_W'(LOCAL_RANK));
        accept   = legal_op && (!op_remote_i || (op_pred_i && rank_hit));
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign apply_o[g] = accept && (op_slot_i == SLOT_W'(g));
    end

endmodule

// File: rtl/txbar_slot.sv
module txbar_slot #(
    parameter int VAL_W      = 21,
    parameter int MAX_ARRIVE = 1 << 20,
    localparam int CNT_W     = $clog2(MAX_ARRIVE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply_i,
    input  logic [2:0]       op_code_i,
    input  logic [VAL_W-1:0] op_value_i,
    output logic             phase_o,
    output logic             valid_o,
    output logic [1:0]       err_o
);
    import txbar_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             phase;
        logic [CNT_W-1:0] arr_left;
        logic [CNT_W-1:0] arr_init;
        logic [VAL_W-1:0] tx_pend;
    } slot_state_t;

    slot_state_t      st_d, st_q;
    bar_op_e          op;
    logic [CNT_W-1:0] arr_nx;
    logic [VAL_W-1:0] tx_nx;
    logic             counts;
    logic             setup_ok;

    always_comb begin
        op       = bar_op_e'(op_code_i);
        st_d     = st_q;
        err_o    = ERR_NONE;
        arr_nx   = st_q.arr_left;
        tx_nx    = st_q.tx_pend;
        counts   = 1'b0;
        setup_ok = (op_value_i != '0) && (op_value_i <= VAL_W'(MAX_ARRIVE));
        if (apply_i) begin
            case (op)
                OP_SETUP: begin
                    if (!setup_ok) begin
                        err_o = ERR_BAD_SETUP;
                    end else begin
                        st_d.valid    = 1'b1;
                        st_d.phase    = 1'b0;
                        st_d.arr_left = CNT_W'(op_value_i);
                        st_d.arr_init = CNT_W'(op_value_i);
                        st_d.tx_pend  = '0;
                    end
                end
                OP_TEARDOWN: begin
                    st_d = '0;
                end
                default: begin
                    if (!st_q.valid) begin
                        err_o = ERR_NOT_VALID;
                    end else begin
                        counts = 1'b1;
                        if (op == OP_ARRIVE || op == OP_ARRIVE_TX) begin
                            if (st_q.arr_left == '0) begin
                                err_o  = ERR_UNDERFLOW;
                                counts = 1'b0;
                            end else begin
                                arr_nx = st_q.arr_left - 1'b1;
                            end
                        end
                        if (op == OP_ARRIVE_TX || op == OP_ANNOUNCE_TX) begin
                            tx_nx = st_q.tx_pend + op_value_i;
                        end
                        if (op == OP_FINISH_TX) begin
                            if (op_value_i > st_q.tx_pend) begin
                                err_o  = ERR_UNDERFLOW;
                                counts = 1'b0;
                            end else begin
                                tx_nx = st_q.tx_pend - op_value_i;
                            end
                        end
                    end
                end
            endcase
        end
        if (counts) begin
            if (arr_nx == '0 && tx_nx == '0) begin
                st_d.phase    = ~st_q.phase;
                st_d.arr_left = st_q.arr_init;
                st_d.tx_pend  = '0;
            end else begin
                st_d.arr_left = arr_nx;
                st_d.tx_pend  = tx_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign valid_o = st_q.valid;

    // R1: an accepted setup arms the object
    p_setup_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_code_i == OP_SETUP && op_value_i != '0 && op_value_i <= VAL_W'(MAX_ARRIVE))
        |=> (st_q.valid && !st_q.phase && st_q.arr_left == CNT_W'($past(op_value_i)) && st_q.tx_pend == '0));

    // R2: a zero setup count changes nothing
    p_bad_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && op_code_i == OP_SETUP && op_value_i == '0) |=> $stable(st_q));

    // R3: state moves only under an accepted command
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(st_q));

    // R7: an underflow leaves the counters alone
    p_underflow_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == ERR_UNDERFLOW) |=> $stable(st_q));

    // R11: commands on an invalid object are dropped
    p_invalid_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && !st_q.valid && op_code_i != OP_SETUP && op_code_i != OP_TEARDOWN)
        |=> $stable(st_q));

endmodule

// File: rtl/txbar_trywait.sv
module txbar_trywait #(
    parameter int NUM_SLOTS     = 4,
    parameter int TIMEOUT_TICKS = 10000000,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int TMO_W        = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic                 parity_i,
    input  logic [NUM_SLOTS-1:0] phase_i,
    output logic                 done_o,
    output logic                 ok_o,
    output logic                 busy_o
);
    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic              parity;
        logic [TMO_W-1:0]  ticks;
        logic              done;
        logic              ok;
    } try_state_t;

    try_state_t tw_d, tw_q;
    logic       closed;

    always_comb begin
        tw_d      = tw_q;
        tw_d.done = 1'b0;
        closed    = phase_i[tw_q.slot] != tw_q.parity;
        if (tw_q.busy) begin
            if (closed) begin
                tw_d.busy = 1'b0;
                tw_d.done = 1'b1;
                tw_d.ok   = 1'b1;
            end else if (tw_q.ticks == TMO_W'(TIMEOUT_TICKS - 1)) begin
                tw_d.busy = 1'b0;
                tw_d.done = 1'b1;
                tw_d.ok   = 1'b0;
            end else begin
                tw_d.ticks = tw_q.ticks + 1'b1;
            end
        end else if (req_i) begin
            tw_d.busy   = 1'b1;
            tw_d.slot   = slot_i;
            tw_d.parity = parity_i;
            tw_d.ticks  = '0;
            tw_d.ok     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tw_q <= '0;
        end else begin
            tw_q <= tw_d;
        end
    end

    assign done_o = tw_q.done;
    assign ok_o   = tw_q.ok;
    assign busy_o = tw_q.busy;

    // R10: every completion ends a poll that was running
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R10: the poll never runs past its tick limit
    p_tick_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tw_q.ticks < TMO_W'(TIMEOUT_TICKS)));

endmodule

// File: rtl/phase_tx_barrier.sv
module phase_tx_barrier #(
    parameter int NUM_SLOTS     = 4,
    parameter int VAL_W         = 21,
    parameter int MAX_ARRIVE    = 1 << 20,
    parameter int RANK_W        = 2,
    parameter int LOCAL_RANK    = 0,
    parameter int TIMEOUT_TICKS = 10000000,
    localparam int SLOT_W       = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op_code,
    input  logic [SLOT_W-1:0]    op_slot,
    input  logic [VAL_W-1:0]     op_value,
    input  logic                 op_remote,
    input  logic [RANK_W-1:0]    op_rank,
    input  logic                 op_pred,
    input  logic [SLOT_W-1:0]    wait_slot,
    input  logic                 wait_parity,
    output logic                 wait_done,
    input  logic                 try_req,
    input  logic [SLOT_W-1:0]    try_slot,
    input  logic                 try_parity,
    output logic                 try_done,
    output logic                 try_ok,
    output logic                 try_busy,
    output logic [1:0]           err_code,
    output logic [NUM_SLOTS-1:0] phase_o,
    output logic [NUM_SLOTS-1:0] valid_o
);
    typedef struct packed {
        logic [1:0] err;
    } top_state_t;

    top_state_t           top_d, top_q;
    logic [NUM_SLOTS-1:0] apply;
    logic [1:0]           slot_err [NUM_SLOTS];

    txbar_route #(
        .NUM_SLOTS  (NUM_SLOTS),
        .RANK_W     (RANK_W),
        .LOCAL_RANK (LOCAL_RANK)
    ) i_route (
        .op_code_i   (op_code),
        .op_slot_i   (op_slot),
        .op_remote_i (op_remote),
        .op_rank_i   (op_rank),
        .op_pred_i   (op_pred),
        .apply_o     (apply)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        txbar_slot #(
            .VAL_W      (VAL_W),
            .MAX_ARRIVE (MAX_ARRIVE)
        ) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .apply_i    (apply[g]),
            .op_code_i  (op_code),
            .op_value_i (op_value),
            .phase_o    (phase_o[g]),
            .valid_o    (valid_o[g]),
            .err_o      (slot_err[g])
        );
    end

    txbar_trywait #(
        .NUM_SLOTS     (NUM_SLOTS),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) i_trywait (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (try_req),
        .slot_i   (try_slot),
        .parity_i (try_parity),
        .phase_i  (phase_o),
        .done_o   (try_done),
        .ok_o     (try_ok),
        .busy_o   (try_busy)
    );

    always_comb begin
        top_d.err = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            top_d.err = top_d.err | slot_err[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign err_code  = top_q.err;
    assign wait_done = phase_o[wait_slot] ^ wait_parity;

    // R8: a remote command with a cleared predicate has no effect
    p_pred_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_remote && !op_pred && op_code != 3'd0)
        |=> (err_code == 2'd0 && $stable(phase_o) && $stable(valid_o)));

    // R8: a remote command for another rank has no effect
    p_rank_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_remote && op_rank != RANK_W'(LOCAL_RANK))
        |=> (err_code == 2'd0 && $stable(phase_o) && $stable(valid_o)));

    // R11: nothing is valid straight after reset
    p_reset_invalid_r11: assert property (@(posedge clk)
        !$past(rst_n) |-> (valid_o == '0 && err_code == 2'd0));

endmodule

// File: tb/test_phase_tx_barrier.sv
module test_phase_tx_barrier;

    localparam int NS   = 4;
    localparam int VW   = 21;
    localparam int MAXA = 1 << 20;
    localparam int RK   = 2;
    localparam int TMO  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_code = '0;
    logic [1:0]    op_slot = '0;
    logic [VW-1:0] op_value = '0;
    logic          op_remote = 1'b0;
    logic [1:0]    op_rank = '0;
    logic          op_pred = 1'b0;
    logic [1:0]    wait_slot = '0;
    logic          wait_parity = 1'b0;
    logic          wait_done;
    logic          try_req = 1'b0;
    logic [1:0]    try_slot = '0;
    logic          try_parity = 1'b0;
    logic          try_done, try_ok, try_busy;
    logic [1:0]    err_code;
    logic [NS-1:0] phase_o, valid_o;

    int n_chk = 0;
    int n_fail = 0;

    bit m_valid [NS];
    bit m_phase [NS];
    int m_left  [NS];
    int m_init  [NS];
    int m_tx    [NS];

    always #2 clk = ~clk;

    phase_tx_barrier #(
        .NUM_SLOTS(NS), .VAL_W(VW), .MAX_ARRIVE(MAXA), .RANK_W(2),
        .LOCAL_RANK(RK), .TIMEOUT_TICKS(TMO)
    ) i_phase_tx_barrier (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_slot(op_slot),
        .op_value(op_value), .op_remote(op_remote), .op_rank(op_rank),
        .op_pred(op_pred), .wait_slot(wait_slot), .wait_parity(wait_parity),
        .wait_done(wait_done), .try_req(try_req), .try_slot(try_slot),
        .try_parity(try_parity), .try_done(try_done), .try_ok(try_ok),
        .try_busy(try_busy), .err_code(err_code), .phase_o(phase_o),
        .valid_o(valid_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] m_phase_vec();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = m_phase[i];
        return v;
    endfunction

    function automatic logic [NS-1:0] m_valid_vec();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = m_valid[i];
        return v;
    endfunction

    // Steps the model by one command, returns the expected error code.
    function automatic int model_op(int op, int s, int v, bit rem, int rk, bit pd);
        int err = 0;
        bit go = 1'b0;
        if (op == 0 || op == 7) return 0;
        if (rem && !(pd && rk == RK)) return 0;
        if (op == 1) begin
            if (v == 0 || v > MAXA) return 1;
            m_valid[s] = 1; m_phase[s] = 0; m_left[s] = v; m_init[s] = v; m_tx[s] = 0;
            return 0;
        end
        if (op == 6) begin
            m_valid[s] = 0; m_phase[s] = 0; m_left[s] = 0; m_init[s] = 0; m_tx[s] = 0;
            return 0;
        end
        if (!m_valid[s]) return 2;
        if ((op == 2 || op == 3) && m_left[s] == 0) return 3;
        if (op == 5 && v > m_tx[s]) return 3;
        if (op == 2 || op == 3) m_left[s]--;
        if (op == 3 || op == 4) m_tx[s] += v;
        if (op == 5) m_tx[s] -= v;
        go = (m_left[s] == 0 && m_tx[s] == 0);
        if (go) begin
            m_phase[s] = ~m_phase[s];
            m_left[s]  = m_init[s];
        end
        return err;
    endfunction

    function automatic string tag_of(int op, bit rem, bit pd, int rk, int e);
        if (rem && !(pd && rk == RK)) return "R8";
        if (e == 1) return "R2";
        if (e == 2) return "R11";
        if (e == 3) return "R7";
        case (op)
            1: return "R1";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R11";
        endcase
    endfunction

    // Called just after a falling edge; returns just after the next one.
    task automatic do_op(int op, int s, int v, bit rem, int rk, bit pd);
        int e;
        string t;
        op_code = 3'(op); op_slot = 2'(s); op_value = VW'(v);
        op_remote = rem; op_rank = 2'(rk); op_pred = pd;
        wait_slot = 2'($urandom % NS); wait_parity = 1'($urandom % 2);
        e = model_op(op, s, v, rem, rk, pd);
        t = tag_of(op, rem, pd, rk, e);
        @(posedge clk);
        @(negedge clk);
        op_code = '0; op_remote = 1'b0;
        chk({t, " err"}, 32'(err_code), 32'(e));
        chk({t, " phase"}, 32'(phase_o), 32'(m_phase_vec()));
        chk({t, " valid"}, 32'(valid_o), 32'(m_valid_vec()));
        chk("R9 test-wait", 32'(wait_done), 32'(m_phase[wait_slot] ^ wait_parity));
    endtask

    // Try-wait: arr_at >= 0 drives an arrive on slot s at that edge count.
    task automatic try_run(string t, int s, bit par, int arr_at, int exp_n, bit exp_ok);
        int n = 0;
        int e;
        try_slot = 2'(s); try_parity = par; try_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        try_req = 1'b0;
        while (n < 100) begin
            if (n == arr_at) begin
                op_code = 3'd2; op_slot = 2'(s); op_remote = 1'b0;
                e = model_op(2, s, 0, 1'b0, 0, 1'b0);
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            op_code = '0;
            if (try_done) break;
        end
        chk({t, " done cycle"}, 32'(n), 32'(exp_n));
        chk({t, " ok"}, 32'(try_ok), 32'(exp_ok));
        chk({t, " phase"}, 32'(phase_o), 32'(m_phase_vec()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NS; i++) begin
            m_valid[i] = 0; m_phase[i] = 0; m_left[i] = 0; m_init[i] = 0; m_tx[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 reset valid", 32'(valid_o), 32'd0);
        chk("R11 reset phase", 32'(phase_o), 32'd0);
        chk("R11 reset err", 32'(err_code), 32'd0);
        chk("R10 reset busy", 32'(try_busy), 32'd0);

        do_op(2, 0, 0, 0, 0, 0);          // R11 arrive on invalid object
        for (int i = 0; i < NS; i++) do_op(1, i, 2, 0, 0, 0);   // R1
        do_op(1, 1, 0, 0, 0, 0);          // R2 zero count
        do_op(1, 1, MAXA + 1, 0, 0, 0);   // R2 above limit
        do_op(1, 3, MAXA, 0, 0, 0);       // R1 limit accepted
        do_op(2, 3, 0, 0, 0, 0);          // R3 no close
        do_op(1, 3, 1, 0, 0, 0);
        do_op(3, 3, 8, 0, 0, 0);          // R4 last arrival, bytes pending
        do_op(2, 3, 0, 0, 0, 0);          // R7 arrival underflow
        do_op(4, 3, 2, 0, 0, 0);          // R5
        do_op(5, 3, 5, 0, 0, 0);          // R6 partial
        do_op(5, 3, 9, 0, 0, 0);          // R7 byte underflow
        do_op(5, 3, 5, 0, 0, 0);          // R6 closes phase
        do_op(2, 2, 0, 1, RK, 0);         // R8 predicate off
        do_op(2, 2, 0, 1, RK + 1, 1);     // R8 wrong rank
        do_op(2, 2, 0, 1, RK, 1);         // R8 accepted
        do_op(2, 2, 0, 1, RK, 1);         // R8 closes phase
        do_op(6, 2, 0, 0, 0, 0);          // R11 teardown
        do_op(5, 2, 0, 0, 0, 0);          // R11 use after teardown

        do_op(1, 0, 1, 0, 0, 0);
        try_run("R10 timeout", 0, 1'b0, -1, TMO, 1'b0);
        do_op(2, 0, 0, 0, 0, 0);
        try_run("R10 immediate", 0, 1'b0, -1, 1, 1'b1);
        try_run("R10 closes during poll", 0, 1'b1, 0, 2, 1'b1);

        for (int k = 0; k < 600; k++) begin
            int r, op, v;
            bit rem;
            r = $urandom % 16;
            v = 0;
            if (r < 2) begin op = 1; v = $urandom % 4; end
            else if (r < 7) op = 2;
            else if (r < 10) begin op = 3; v = $urandom % 6; end
            else if (r < 12) begin op = 4; v = $urandom % 6; end
            else if (r < 15) begin op = 5; v = $urandom % 7; end
            else op = (($urandom % 4) == 0) ? 6 : 2;
            rem = (($urandom % 4) == 0);
            do_op(op, $urandom % NS, v, rem, $urandom % 4, 1'($urandom % 2));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule